// File: doc/BRIEF.md
# Code-Offset Helper Data Sequencer

This block runs the helper-data stage of a fuzzy extractor built on memory start-up values. The response arrives as a serial bit stream and fills a segment register one codeword wide, a fixed number of blocks per run. Each run is either an enrollment or a reconstruction.

During enrollment, the first message-width bits of each segment go to an external error-correcting encoder. The codeword that comes back is XORed with the whole segment in one step. The result is offered as helper data on a write port, tagged with the block number. Enrollment is meant to happen once, in a trusted setting.

During reconstruction, which happens at every power-up, the block fetches the stored helper data for each block by its number. It XORs that data with the fresh, noisy segment and hands the noisy codeword to an external decoder. Every external exchange uses a valid/ready handshake, and the sequence stalls until the other side responds. With the default sizes (127-bit codewords, 15 message bits, 12 blocks) a run yields 180 message bits and consumes 1524 response bits.

Top module: `co_helper_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, resp_ready, enc_req_valid, enc_cw_ready, hd_wr_valid, hd_rd_ready, dec_valid and done are all 0.
- R2: Within a block, the i-th accepted response bit (counting from 0) becomes segment bit i. enc_msg carries segment bits MSG_BITS-1..0, so the first accepted bit is enc_msg bit 0.
- R3: In enrollment, hd_wr_data equals the codeword accepted on enc_cw XOR the segment, and hd_wr_index equals the block number (0 for the first block).
- R4: In reconstruction, dec_data equals the helper word accepted on hd_rd_data XOR the freshly collected segment, and hd_rd_index equals the block number.
- R5: Once enc_req_valid, hd_wr_valid or dec_valid is raised, it stays high with unchanged data until the matching ready is seen.
- R6: resp_ready is high only while a segment is being collected. Exactly CW_BITS bits are accepted per block, and bits offered at any other time have no effect on later outputs.
- R7: After N_BLOCKS blocks, done rises in the cycle after the last helper write (enrollment) or the last decoder hand-off (reconstruction). It stays high until the next start and is low during a run.
- R8: The mode is captured at start. A start pulse during a run is ignored and does not change the mode or the block number.
- R9: An enrollment run never raises hd_rd_ready or dec_valid. A reconstruction run never raises enc_req_valid or hd_wr_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a run when idle or done |
| mode_recon | input | 1 | Mode sampled at start: 0 enrollment, 1 reconstruction |
| resp_valid | input | 1 | Response bit offered |
| resp_bit | input | 1 | Serial response bit |
| resp_ready | output | 1 | Response bit accepted this cycle when valid |
| enc_req_valid | output | 1 | Message offered to encoder |
| enc_req_ready | input | 1 | Encoder takes the message |
| enc_msg | output | MSG_BITS | Message bits for the encoder |
| enc_cw_valid | input | 1 | Encoder returns a codeword |
| enc_cw_ready | output | 1 | Block takes the codeword |
| enc_cw | input | CW_BITS | Codeword from encoder |
| hd_wr_valid | output | 1 | Helper word offered to storage |
| hd_wr_ready | input | 1 | Storage takes the helper word |
| hd_wr_index | output | IDX_W | Block number of the helper word |
| hd_wr_data | output | CW_BITS | Helper word |
| hd_rd_ready | output | 1 | Block requests stored helper word |
| hd_rd_index | output | IDX_W | Block number requested |
| hd_rd_valid | input | 1 | Storage returns the helper word |
| hd_rd_data | input | CW_BITS | Stored helper word |
| dec_valid | output | 1 | Noisy codeword offered to decoder |
| dec_ready | input | 1 | Decoder takes the codeword |
| dec_data | output | CW_BITS | Noisy codeword |
| done | output | 1 | Run complete |

## Verification
The assertions assume that each external partner asserts its response valid only while the block is waiting for it. They also assume that a start pulse lasts a single cycle. The bench drives enc_cw_valid and hd_rd_valid only after it has seen the matching ready, and it holds each one for exactly one accepted cycle. It also deliberately drives response bits and start pulses while the block is busy, because the block is required to ignore those inputs, and these pulses fall within what the assertions permit.

// File: rtl/cohs_pkg.sv
// Shared types for the code-offset helper sequencer.
package cohs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_SHIFT    = 3'd1,
        ST_ENC_REQ  = 3'd2,
        ST_ENC_WAIT = 3'd3,
        ST_HD_WRITE = 3'd4,
        ST_HD_FETCH = 3'd5,
        ST_DEC_SEND = 3'd6,
        ST_DONE     = 3'd7
    } cohs_state_t;
endpackage

// File: rtl/cohs_segment_reg.sv
// Serial-in segment register. The first accepted bit lands at bit 0.
// Assumes shift_en is only raised while a segment is being collected.
module cohs_segment_reg #(
    parameter int unsigned SEG_BITS = 127
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                shift_en,
    input  logic                bit_in,
    output logic [SEG_BITS-1:0] seg_q,
    output logic                last_bit
);
    localparam int unsigned CNT_W = $clog2(SEG_BITS);

    logic [CNT_W-1:0] cnt_q;

    assign last_bit = (cnt_q == CNT_W'(SEG_BITS - 1));

    // Shift data in from the top and count the bits of the current block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q <= '0;
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (shift_en) begin
            seg_q <= {bit_in, seg_q[SEG_BITS-1:1]};
            cnt_q <= last_bit ? '0 : cnt_q + 1'b1;
        end
    end

    p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(SEG_BITS - 1));
    p_cnt_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && last_bit && !clear) |=> (cnt_q == '0));
endmodule

// File: rtl/cohs_block_ctr.sv
// Counts finished code blocks and flags the final one.
// Assumes step is raised once per finished block.
module cohs_block_ctr #(
    parameter int unsigned NUM_BLOCKS = 12,
    parameter int unsigned IDX_W      = $clog2(NUM_BLOCKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [IDX_W-1:0] idx_q,
    output logic             last_blk
);
    assign last_blk = (idx_q == IDX_W'(NUM_BLOCKS - 1));

    // Advance the block number as each block completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (clear) begin
            idx_q <= '0;
        end else if (step && !last_blk) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    p_idx_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q < IDX_W'(NUM_BLOCKS));
endmodule

// File: rtl/cohs_ctrl.sv
// Sequencing state machine. It picks the enrollment or reconstruction path
// at start and walks each block through collect, exchange and output steps.
// Assumes the handshake partners hold valid until they see ready.
module cohs_ctrl
    import cohs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        mode_recon,
    input  logic        resp_valid,
    input  logic        seg_last,
    input  logic        blk_last,
    input  logic        enc_req_ready,
    input  logic        enc_cw_valid,
    input  logic        hd_wr_ready,
    input  logic        hd_rd_valid,
    input  logic        dec_ready,
    output cohs_state_t state_q,
    output logic        recon_q,
    output logic        begin_run,
    output logic        shift_en,
    output logic        blk_step,
    output logic        capture_enc,
    output logic        capture_hd
);
    cohs_state_t state_d;

    // Decode the strobes that the datapath acts on in this cycle.
    always_comb begin
        begin_run   = start && (state_q == ST_IDLE || state_q == ST_DONE);
        shift_en    = (state_q == ST_SHIFT) && resp_valid;
        capture_enc = (state_q == ST_ENC_WAIT) && enc_cw_valid;
        capture_hd  = (state_q == ST_HD_FETCH) && hd_rd_valid;
        blk_step    = ((state_q == ST_HD_WRITE) && hd_wr_ready) ||
                      ((state_q == ST_DEC_SEND) && dec_ready);
    end

    // Next-state selection for the block sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: if (begin_run) state_d = ST_SHIFT;
            ST_SHIFT:         if (shift_en && seg_last)
                                  state_d = recon_q ? ST_HD_FETCH : ST_ENC_REQ;
            ST_ENC_REQ:       if (enc_req_ready) state_d = ST_ENC_WAIT;
            ST_ENC_WAIT:      if (capture_enc) state_d = ST_HD_WRITE;
            ST_HD_WRITE:      if (blk_step) state_d = blk_last ? ST_DONE : ST_SHIFT;
            ST_HD_FETCH:      if (capture_hd) state_d = ST_DEC_SEND;
            ST_DEC_SEND:      if (blk_step) state_d = blk_last ? ST_DONE : ST_SHIFT;
            default:          state_d = ST_IDLE;
        endcase
    end

    // State and mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            recon_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (begin_run) recon_q <= mode_recon;
        end
    end

    p_mode_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!begin_run) |=> $stable(recon_q));
endmodule

// File: rtl/co_helper_seq.sv
// Code-offset helper data sequencer (top). Enrollment: helper = codeword XOR
// segment, written per block. Reconstruction: noisy codeword = segment XOR
// stored helper, sent to the decoder per block. Assumes CW_BITS >= MSG_BITS.
module co_helper_seq #(
    parameter int unsigned CW_BITS  = 127,
    parameter int unsigned MSG_BITS = 15,
    parameter int unsigned N_BLOCKS = 12,
    parameter int unsigned IDX_W    = $clog2(N_BLOCKS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                mode_recon,
    input  logic                resp_valid,
    input  logic                resp_bit,
    output logic                resp_ready,
    output logic                enc_req_valid,
    input  logic                enc_req_ready,
    output logic [MSG_BITS-1:0] enc_msg,
    input  logic                enc_cw_valid,
    output logic                enc_cw_ready,
    input  logic [CW_BITS-1:0]  enc_cw,
    output logic                hd_wr_valid,
    input  logic                hd_wr_ready,
    output logic [IDX_W-1:0]    hd_wr_index,
    output logic [CW_BITS-1:0]  hd_wr_data,
    output logic                hd_rd_ready,
    output logic [IDX_W-1:0]    hd_rd_index,
    input  logic                hd_rd_valid,
    input  logic [CW_BITS-1:0]  hd_rd_data,
    output logic                dec_valid,
    input  logic                dec_ready,
    output logic [CW_BITS-1:0]  dec_data,
    output logic                done
);
    import cohs_pkg::*;

    cohs_state_t        state;
    logic               recon;
    logic               begin_run, shift_en, blk_step, capture_enc, capture_hd;
    logic               seg_last, blk_last;
    logic [CW_BITS-1:0] seg;
    logic [CW_BITS-1:0] combo_q;
    logic [IDX_W-1:0]   blk_idx;

    cohs_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_recon(mode_recon),
        .resp_valid(resp_valid), .seg_last(seg_last), .blk_last(blk_last),
        .enc_req_ready(enc_req_ready), .enc_cw_valid(enc_cw_valid),
        .hd_wr_ready(hd_wr_ready), .hd_rd_valid(hd_rd_valid),
        .dec_ready(dec_ready), .state_q(state), .recon_q(recon),
        .begin_run(begin_run), .shift_en(shift_en), .blk_step(blk_step),
        .capture_enc(capture_enc), .capture_hd(capture_hd)
    );

    cohs_segment_reg #(.SEG_BITS(CW_BITS)) u_seg (
        .clk(clk), .rst_n(rst_n), .clear(begin_run), .shift_en(shift_en),
        .bit_in(resp_bit), .seg_q(seg), .last_bit(seg_last)
    );

    cohs_block_ctr #(.NUM_BLOCKS(N_BLOCKS), .IDX_W(IDX_W)) u_blk (
        .clk(clk), .rst_n(rst_n), .clear(begin_run), .step(blk_step),
        .idx_q(blk_idx), .last_blk(blk_last)
    );

    // One wide XOR combiner serves both paths; only the second operand differs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            combo_q <= '0;
        end else if (capture_enc) begin
            combo_q <= enc_cw ^ seg;
        end else if (capture_hd) begin
            combo_q <= hd_rd_data ^ seg;
        end
    end

    // Port decode from the sequencer state.
    always_comb begin
        resp_ready    = (state == ST_SHIFT);
        enc_req_valid = (state == ST_ENC_REQ);
        enc_cw_ready  = (state == ST_ENC_WAIT);
        hd_wr_valid   = (state == ST_HD_WRITE);
        hd_rd_ready   = (state == ST_HD_FETCH);
        dec_valid     = (state == ST_DEC_SEND);
        done          = (state == ST_DONE);
        enc_msg       = seg[MSG_BITS-1:0];
        hd_wr_index   = blk_idx;
        hd_rd_index   = blk_idx;
        hd_wr_data    = combo_q;
        dec_data      = combo_q;
    end

    p_enc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_req_valid && !enc_req_ready) |=> (enc_req_valid && $stable(enc_msg)));
    p_hd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hd_wr_valid && !hd_wr_ready) |=> (hd_wr_valid && $stable(hd_wr_data)
                                           && $stable(hd_wr_index)));
    p_dec_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_data)));
    p_write_after_cw_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hd_wr_valid) |-> $past(enc_cw_valid && enc_cw_ready));
    p_dec_after_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_valid) |-> $past(hd_rd_valid && hd_rd_ready));
    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
    p_no_mix_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enc_req_valid) |-> !$past(hd_rd_ready));
endmodule

// File: tb/sim_co_helper_seq.sv
// Bench: small configuration (15-bit codeword, 5-bit message, 3 blocks),
// enrollment followed by several reconstruction runs.
module sim_co_helper_seq;
    localparam int CW = 15;
    localparam int MW = 5;
    localparam int NB = 3;
    localparam int IW = $clog2(NB + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 0, mode_recon = 0, resp_valid = 0, resp_bit = 0;
    logic enc_req_ready = 0, enc_cw_valid = 0, hd_wr_ready = 0;
    logic hd_rd_valid = 0, dec_ready = 0;
    logic [CW-1:0] enc_cw = '0, hd_rd_data = '0;
    logic resp_ready, enc_req_valid, enc_cw_ready, hd_wr_valid, hd_rd_ready;
    logic dec_valid, done;
    logic [MW-1:0] enc_msg;
    logic [IW-1:0] hd_wr_index, hd_rd_index;
    logic [CW-1:0] hd_wr_data, dec_data;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    logic [CW-1:0] helper_mem [NB];
    logic [MW-1:0] msg_mem [NB];

    always #2 clk = ~clk;

    co_helper_seq #(.CW_BITS(CW), .MSG_BITS(MW), .N_BLOCKS(NB)) u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [CW-1:0] cw_fn(input logic [MW-1:0] m);
        return {m ^ 5'b10110, ~m, m};
    endfunction

    function automatic logic resp_fn(input int blk, input int j);
        return 1'(((blk * 5 + j * j + 3) >> 1) ^ ((j % 3) == 0 ? 1 : 0));
    endfunction

    function automatic logic noise_fn(input int sel, input int blk, input int j);
        if (sel == 0) return 1'b0;
        return ((j * 7 + blk * 3 + sel) % 5) == 0;
    endfunction

    // Watchdog: an expired run counts as a failure and still prints the summary.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=<100000", cyc);
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    task automatic pulse_start(input logic m);
        @(negedge clk);
        start = 1; mode_recon = m;
        @(negedge clk);
        start = 0;
    endtask

    task automatic drive_bit(input logic b);
        resp_valid = 1; resp_bit = b;
        while (!resp_ready) @(negedge clk);
        @(negedge clk);
    endtask

    // Collect one block; garbage keeps resp_valid high afterwards.
    task automatic send_block(input int blk, input int nsel, input bit gaps,
                              input bit garbage, output logic [CW-1:0] seg);
        for (int j = 0; j < CW; j++) begin
            logic b;
            b = resp_fn(blk, j) ^ noise_fn(nsel, blk, j);
            seg[j] = b;
            if (gaps && (j % 4) == 3) begin
                resp_valid = 0;
                @(negedge clk);
            end
            drive_bit(b);
        end
        resp_valid = garbage; resp_bit = 1'b1;
    endtask

    task automatic enroll_run();
        logic [CW-1:0] seg;
        logic [CW-1:0] cw;
        pulse_start(1'b0);
        chk("R7 done low in run", 32'(done), 0);
        for (int b = 0; b < NB; b++) begin
            send_block(b, 0, 1'b1, 1'b0, seg);
            while (!enc_req_valid) @(negedge clk);
            chk("R2 message bits", 32'(enc_msg), 32'(seg[MW-1:0]));
            chk("R6 no ready outside collect", 32'(resp_ready), 0);
            chk("R9 enroll no fetch", 32'({hd_rd_ready, dec_valid}), 0);
            for (int s = 0; s < b; s++) @(negedge clk);
            chk("R5 enc request held", 32'({enc_req_valid, enc_msg}), 32'({1'b1, seg[MW-1:0]}));
            enc_req_ready = 1; @(negedge clk); enc_req_ready = 0;
            cw = cw_fn(seg[MW-1:0]);
            chk("R3 cw ready", 32'(enc_cw_ready), 1);
            enc_cw = cw; enc_cw_valid = 1; @(negedge clk); enc_cw_valid = 0;
            chk("R3 helper data", 32'(hd_wr_data), 32'(cw ^ seg));
            chk("R3 helper index", 32'(hd_wr_index), 32'(b));
            for (int s = 0; s < 2; s++) @(negedge clk);
            chk("R5 helper held", 32'({hd_wr_valid, hd_wr_data}), 32'({1'b1, cw ^ seg}));
            helper_mem[b] = hd_wr_data;
            msg_mem[b] = seg[MW-1:0];
            hd_wr_ready = 1; @(negedge clk); hd_wr_ready = 0;
            chk("R7 done after last write", 32'(done), (b == NB - 1) ? 1 : 0);
        end
    endtask

    task automatic recon_run(input int nsel, input bit garbage, input bit late_start);
        logic [CW-1:0] seg;
        pulse_start(1'b1);
        for (int b = 0; b < NB; b++) begin
            send_block(b, nsel, 1'b0, garbage, seg);
            while (!hd_rd_ready) begin
                chk("R9 recon no encoder", 32'({enc_req_valid, hd_wr_valid}), 0);
                @(negedge clk);
            end
            chk("R4 fetch index", 32'(hd_rd_index), 32'(b));
            if (late_start && b == 1) begin
                start = 1; mode_recon = 0; @(negedge clk); start = 0;
                chk("R8 start ignored", 32'({hd_rd_ready, hd_rd_index}), 32'({1'b1, IW'(b)}));
            end
            hd_rd_data = helper_mem[b]; hd_rd_valid = 1; @(negedge clk); hd_rd_valid = 0;
            chk("R4 noisy codeword", 32'(dec_data), 32'(seg ^ helper_mem[b]));
            if (nsel == 0)
                chk("R4 clean codeword", 32'(dec_data), 32'(cw_fn(msg_mem[b])));
            @(negedge clk);
            chk("R5 dec held", 32'({dec_valid, dec_data}), 32'({1'b1, seg ^ helper_mem[b]}));
            chk("R6 garbage ignored", 32'(resp_ready), 0);
            dec_ready = 1; @(negedge clk); dec_ready = 0;
            chk("R7 done after last hand-off", 32'(done), (b == NB - 1) ? 1 : 0);
        end
        resp_valid = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", 32'({resp_ready, enc_req_valid, enc_cw_ready, hd_wr_valid,
                                     hd_rd_ready, dec_valid, done}), 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 after reset", 32'({resp_ready, enc_req_valid, hd_wr_valid, hd_rd_ready,
                                   dec_valid, done}), 0);
        enroll_run();
        repeat (4) @(negedge clk);
        chk("R7 done stays", 32'(done), 1);
        recon_run(1, 1'b0, 1'b0);
        recon_run(2, 1'b1, 1'b1);
        recon_run(0, 1'b1, 1'b0);
        repeat (2) @(negedge clk);
        chk("R7 done stays after recon", 32'(done), 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule